// File: doc/BRIEF.md
# Ethernet PHY Management Bus Master

This block is the host-side master of the two-wire PHY management bus. It divides its own clock down to a management clock (MDC) and moves serial frames over the data line (MDIO). The line is shared, so the block does not use a bidirectional pin. It presents three signals instead: an output value, an output enable and an input sample, and the pad ring combines them. The host asks for work through three level requests: write one PHY register, read one PHY register, or poll one register without end.

For each accepted request the block sends an optional run of 32 ones. It then sends the start pattern, the opcode, the PHY address, the register address, a turnaround and 16 data bits. It marks the acceptance of a write or a read with a one-cycle pulse, which the host uses to clear its request bit. It reports finished reads with a one-cycle update strobe. In polling mode it tracks link health from bit 2 of each result, and it holds a qualifier flag high until the first poll result arrives.

Top module: `mdio_master`

## Requirements
- R1: While reset is held, mdc, mdio_oe, busy, write_start, read_start, rd_data_update, link_fail and rd_data are 0 and scan_invalid is 1.
- R2: The MDC period is 2*floor(max(clk_div,2)/2) host clocks, so any divider value below 2 behaves as 2.
- R3: A write frame drives 64 bits at MDC rising edges, MSB first. The bits are 32 ones, then 01, then opcode 01, then the 5-bit PHY address, the 5-bit register address, the pattern 10 and the 16 write-data bits. mdio_oe is 1 for all of them.
- R4: With skip_preamble set, the frame has only its final 32 bits and the run of ones is left out.
- R5: A read frame drives 01, opcode 10, the PHY address and the register address. It releases the line (mdio_oe = 0) for the 2 turnaround bits and 16 data bits. It samples mdio_in at each MDC rise of the data bits, MSB first, and shows the word on rd_data when the frame ends.
- R6: mdio_out and mdio_oe change only on the clock edge at which mdc falls.
- R7: write_start pulses for one cycle when a write is accepted, read_start when a read is accepted, and neither pulses for a poll frame. The two never pulse together.
- R8: When several requests are pending, write is served before read, and read is served before poll.
- R9: busy rises in the same cycle as a start pulse and stays high through the last data bit. rd_data_update pulses in the cycle in which busy falls.
- R10: While req_scan is high and nothing else is pending, read frames repeat back to back. One cycle after each poll result, link_fail becomes the inverse of bit 2 of that result. Plain reads never change link_fail.
- R11: scan_invalid is 1 while req_scan is low. It goes to 0 one cycle after the first poll result that completes while req_scan is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_div | input | 8 | MDC divider |
| skip_preamble | input | 1 | Leave out the run of 32 ones |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Register address in the PHY |
| wr_data | input | 16 | Data for write frames |
| req_write | input | 1 | Write request (level) |
| req_read | input | 1 | Read request (level) |
| req_scan | input | 1 | Continuous poll request (level) |
| mdio_in | input | 1 | Sampled MDIO line |
| mdio_out | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO driver enable |
| mdc | output | 1 | Management clock |
| busy | output | 1 | Frame in progress |
| rd_data | output | 16 | Last read or poll result |
| rd_data_update | output | 1 | One-cycle strobe: new rd_data |
| write_start | output | 1 | One-cycle pulse: write accepted |
| read_start | output | 1 | One-cycle pulse: read accepted |
| link_fail | output | 1 | Link bit of last poll result was 0 |
| scan_invalid | output | 1 | No poll result yet in this poll session |

## Verification
The hardest state to reach is a mixed queue. In it, all three requests are pending at once, a poll session has started but has no result yet, and a link-bit change has to reach link_fail and scan_invalid with the right one-cycle lag. The bench raises write, read and poll together while a PHY model drives chosen response words during the released data bits. It then follows the pulses, the frame opcodes and both flags across the write, the read and two successive poll frames. After that it drops the poll request while a frame is in flight.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_WR   = 2'd1,
        OP_RD   = 2'd2,
        OP_SCAN = 2'd3
    } mdio_op_e;

    localparam logic [1:0] SOF_BITS  = 2'b01;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] TA_DRIVE  = 2'b10;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             fall_tick_o,
    output logic             rise_tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] half_m1;
    logic             at_edge;

    always_comb begin
        div_eff = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
        half_m1 = (div_eff >> 1) - 1'b1;
        // ">=" keeps the count sane when the divider shrinks mid-phase
        at_edge = (st_q.cnt >= half_m1);
        st_d    = st_q;
        if (at_edge) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mdc_o       = st_q.mdc;
    assign fall_tick_o = at_edge & st_q.mdc;
    assign rise_tick_o = at_edge & ~st_q.mdc;

endmodule

// File: rtl/mdio_cmd_arb.sv
module mdio_cmd_arb
    import mdio_master_pkg::*;
(
    input  logic     req_wr_i,
    input  logic     req_rd_i,
    input  logic     req_scan_i,
    output mdio_op_e op_o
);

    always_comb begin
        if (req_wr_i)        op_o = OP_WR;
        else if (req_rd_i)   op_o = OP_RD;
        else if (req_scan_i) op_o = OP_SCAN;
        else                 op_o = OP_IDLE;
    end

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_master_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_tick_i,
    input  logic              rise_tick_i,
    input  mdio_op_e          op_i,
    input  logic              nopre_i,
    input  logic [ADDR_W-1:0] phy_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              mdio_in_i,
    output logic              mdio_out_o,
    output logic              mdio_oe_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rupd_o,
    output logic              wstart_o,
    output logic              rstart_o,
    output logic              sdone_o
);

    localparam int FRM_W    = 6 + 2 * ADDR_W + DATA_W;
    localparam int TOTAL    = PRE_LEN + FRM_W;
    localparam int POS_W    = $clog2(TOTAL + 1);
    localparam int REL_POS  = PRE_LEN + 4 + 2 * ADDR_W;
    localparam int DATA_POS = REL_POS + 2;
    localparam int LAST_POS = TOTAL - 1;

    typedef struct packed {
        logic              busy;
        mdio_op_e          op;
        logic [POS_W-1:0]  pos;
        logic [FRM_W-1:0]  frame;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] rdat;
        logic              out;
        logic              oe;
        logic              upd;
        logic              ws;
        logic              rs;
        logic              sdone;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic [FRM_W-1:0] ld_frame;
    logic [POS_W-1:0] nxt_pos;
    logic             is_wr_req;

    always_comb begin
        is_wr_req = (op_i == OP_WR);
        ld_frame  = {SOF_BITS, (is_wr_req ? OPC_WRITE : OPC_READ), phy_i, reg_i,
                     TA_DRIVE, (is_wr_req ? wdata_i : {DATA_W{1'b0}})};
        nxt_pos   = st_q.pos + 1'b1;

        st_d       = st_q;
        st_d.upd   = 1'b0;
        st_d.ws    = 1'b0;
        st_d.rs    = 1'b0;
        st_d.sdone = 1'b0;

        if (!st_q.busy) begin
            if (fall_tick_i && (op_i != OP_IDLE)) begin
                st_d.busy  = 1'b1;
                st_d.op    = op_i;
                st_d.oe    = 1'b1;
                st_d.ws    = is_wr_req;
                st_d.rs    = (op_i == OP_RD);
                st_d.shreg = '0;
                if (nopre_i || (PRE_LEN == 0)) begin
                    st_d.pos   = POS_W'(PRE_LEN);
                    st_d.out   = ld_frame[FRM_W-1];
                    st_d.frame = ld_frame << 1;
                end else begin
                    st_d.pos   = '0;
                    st_d.out   = 1'b1;
                    st_d.frame = ld_frame;
                end
            end
        end else begin
            if (rise_tick_i && (st_q.op != OP_WR) && (int'(st_q.pos) >= DATA_POS))
                st_d.shreg = {st_q.shreg[DATA_W-2:0], mdio_in_i};
            if (fall_tick_i) begin
                if (int'(st_q.pos) == LAST_POS) begin
                    st_d.busy  = 1'b0;
                    st_d.oe    = 1'b0;
                    st_d.out   = 1'b1;
                    st_d.sdone = (st_q.op == OP_SCAN);
                    if (st_q.op != OP_WR) begin
                        st_d.upd  = 1'b1;
                        st_d.rdat = st_q.shreg;
                    end
                end else begin
                    st_d.pos = nxt_pos;
                    if (int'(nxt_pos) < PRE_LEN) begin
                        st_d.out = 1'b1;
                    end else begin
                        st_d.out   = st_q.frame[FRM_W-1];
                        st_d.frame = st_q.frame << 1;
                    end
                    st_d.oe = (st_q.op == OP_WR) || (int'(nxt_pos) < REL_POS);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mdio_out_o = st_q.out;
    assign mdio_oe_o  = st_q.oe;
    assign busy_o     = st_q.busy;
    assign rdata_o    = st_q.rdat;
    assign rupd_o     = st_q.upd;
    assign wstart_o   = st_q.ws;
    assign rstart_o   = st_q.rs;
    assign sdone_o    = st_q.sdone;

    // Line released during turnaround and data of every read-type frame
    assert_read_release_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && (st_q.op != OP_WR) && (int'(st_q.pos) >= REL_POS)) |-> !st_q.oe);

    // Write frames keep the line driven for their whole length
    assert_write_driven_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && (st_q.op == OP_WR)) |-> st_q.oe);

endmodule

// File: rtl/mdio_scan_mon.sv
module mdio_scan_mon (
    input  logic clk,
    input  logic rst,
    input  logic req_scan_i,
    input  logic sdone_i,
    input  logic link_bit_i,
    output logic link_fail_o,
    output logic invalid_o
);

    typedef struct packed {
        logic link_fail;
        logic invalid;
    } mon_st_t;

    mon_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sdone_i) st_d.link_fail = ~link_bit_i;
        if (!req_scan_i)  st_d.invalid = 1'b1;
        else if (sdone_i) st_d.invalid = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{link_fail: 1'b0, invalid: 1'b1};
        else     st_q <= st_d;
    end

    assign link_fail_o = st_q.link_fail;
    assign invalid_o   = st_q.invalid;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_master_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int PRE_LEN  = 32,
    parameter int LINK_BIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              skip_preamble,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              req_write,
    input  logic              req_read,
    input  logic              req_scan,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              mdc,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_data_update,
    output logic              write_start,
    output logic              read_start,
    output logic              link_fail,
    output logic              scan_invalid
);

    logic     fall_tick;
    logic     rise_tick;
    logic     scan_done;
    mdio_op_e op_sel;

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk         (clk),
        .rst         (rst),
        .div_i       (clk_div),
        .mdc_o       (mdc),
        .fall_tick_o (fall_tick),
        .rise_tick_o (rise_tick)
    );

    mdio_cmd_arb u_arb (
        .req_wr_i   (req_write),
        .req_rd_i   (req_read),
        .req_scan_i (req_scan),
        .op_o       (op_sel)
    );

    mdio_frame_eng #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PRE_LEN (PRE_LEN)
    ) u_eng (
        .clk         (clk),
        .rst         (rst),
        .fall_tick_i (fall_tick),
        .rise_tick_i (rise_tick),
        .op_i        (op_sel),
        .nopre_i     (skip_preamble),
        .phy_i       (phy_addr),
        .reg_i       (reg_addr),
        .wdata_i     (wr_data),
        .mdio_in_i   (mdio_in),
        .mdio_out_o  (mdio_out),
        .mdio_oe_o   (mdio_oe),
        .busy_o      (busy),
        .rdata_o     (rd_data),
        .rupd_o      (rd_data_update),
        .wstart_o    (write_start),
        .rstart_o    (read_start),
        .sdone_o     (scan_done)
    );

    mdio_scan_mon u_mon (
        .clk         (clk),
        .rst         (rst),
        .req_scan_i  (req_scan),
        .sdone_i     (scan_done),
        .link_bit_i  (rd_data[LINK_BIT]),
        .link_fail_o (link_fail),
        .invalid_o   (scan_invalid)
    );

    assert_drive_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mdio_out) || !$stable(mdio_oe)) |-> $fell(mdc));

    assert_start_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({write_start, read_start}));

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (write_start || read_start) |-> $rose(busy));

    assert_update_end_R9: assert property (@(posedge clk) disable iff (rst)
        rd_data_update |-> $fell(busy));

    assert_link_timing_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(link_fail) |-> $past(rd_data_update));

    assert_invalid_clear_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(scan_invalid) |-> $past(rd_data_update));

endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  clk_div;
    logic        skip_preamble;
    logic [4:0]  phy_addr, reg_addr;
    logic [15:0] wr_data;
    logic        req_write, req_read, req_scan;
    logic        mdio_in;
    logic        mdio_out, mdio_oe, mdc, busy;
    logic [15:0] rd_data;
    logic        rd_data_update, write_start, read_start, link_fail, scan_invalid;

    always #2.5 clk = ~clk;

    mdio_master dut_i (
        .clk(clk), .rst(rst), .clk_div(clk_div), .skip_preamble(skip_preamble),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .req_write(req_write), .req_read(req_read), .req_scan(req_scan),
        .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdc(mdc),
        .busy(busy), .rd_data(rd_data), .rd_data_update(rd_data_update),
        .write_start(write_start), .read_start(read_start),
        .link_fail(link_fail), .scan_invalid(scan_invalid)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // monitor / PHY model state
    logic        mdc_p, busy_p, out_p, oe_p;
    logic [63:0] cap_b, cap_o, fr_b, fr_o;
    int          cap_n, fr_n, frames, ws_n, rs_n, rises, last_rise, period, bad_drive, upd_n;
    logic        upd_busy;
    logic [15:0] phy_resp;
    logic        cur_nopre;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst) begin
            mdc_p = 0; busy_p = 0; out_p = mdio_out; oe_p = mdio_oe;
            cap_n = 0; cap_b = '0; cap_o = '0; fr_n = 0; fr_b = '0; fr_o = '0;
            frames = 0; ws_n = 0; rs_n = 0; rises = 0; last_rise = 0; period = 0;
            bad_drive = 0; upd_n = 0; upd_busy = 0; mdio_in = 1'b1;
        end else begin
            if (busy && !busy_p) begin cap_n = 0; cap_b = '0; cap_o = '0; end
            if (mdc && !mdc_p) begin
                period = cyc - last_rise; last_rise = cyc; rises++;
                if (busy) begin
                    cap_b = {cap_b[62:0], mdio_out};
                    cap_o = {cap_o[62:0], mdio_oe};
                    cap_n++;
                end
            end
            if (!mdc && mdc_p) begin
                int len;
                len = cur_nopre ? 32 : 64;
                if (busy && cap_n >= len - 16 && cap_n < len)
                    mdio_in = phy_resp[15 - (cap_n - (len - 16))];
                else
                    mdio_in = 1'b1;
            end
            if ((mdio_out !== out_p || mdio_oe !== oe_p) && !(mdc_p && !mdc)) bad_drive++;
            if (!busy && busy_p) begin fr_b = cap_b; fr_o = cap_o; fr_n = cap_n; frames++; end
            if (write_start) ws_n++;
            if (read_start) rs_n++;
            if (rd_data_update) begin upd_n++; upd_busy = busy; end
            mdc_p = mdc; busy_p = busy; out_p = mdio_out; oe_p = mdio_oe;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_frame();
        int f0;
        f0 = frames;
        while (frames == f0) step();
    endtask

    task automatic do_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d, input bit np);
        logic [31:0] f32;
        logic [63:0] e, eo;
        cur_nopre = np; skip_preamble = np; phy_addr = p; reg_addr = r; wr_data = d;
        req_write = 1'b1;
        do step(); while (!write_start);
        chk(busy == 1'b1, "R9 busy with write_start", busy, 1);
        chk(read_start == 1'b0, "R7 no read_start on write", read_start, 0);
        req_write = 1'b0;
        wait_frame();
        f32 = {2'b01, 2'b01, p, r, 2'b10, d};
        e   = np ? {32'h0, f32} : {32'hFFFF_FFFF, f32};
        eo  = np ? {32'h0, 32'hFFFF_FFFF} : {64{1'b1}};
        if (np) begin
            chk(fr_n == 32, "R4 frame length", fr_n, 32);
            chk(fr_b == e, "R4 write bits", fr_b, e);
        end else begin
            chk(fr_n == 64, "R3 frame length", fr_n, 64);
            chk(fr_b == e, "R3 write bits", fr_b, e);
        end
        chk(fr_o == eo, "R3 write drive enable", fr_o, eo);
    endtask

    task automatic do_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] resp, input bit np);
        logic [31:0] f32, o32;
        logic [63:0] e, eo;
        int u0;
        logic lf0;
        lf0 = link_fail;
        cur_nopre = np; skip_preamble = np; phy_addr = p; reg_addr = r; phy_resp = resp;
        req_read = 1'b1;
        do step(); while (!read_start);
        chk(write_start == 1'b0, "R7 no write_start on read", write_start, 0);
        chk(busy == 1'b1, "R9 busy with read_start", busy, 1);
        req_read = 1'b0;
        u0 = upd_n;
        wait_frame();
        f32 = {2'b01, 2'b10, p, r, 18'h0};
        o32 = {14'h3FFF, 18'h0};
        e   = np ? {32'h0, f32} : {32'hFFFF_FFFF, f32};
        eo  = np ? {32'h0, o32} : {32'hFFFF_FFFF, o32};
        chk(fr_n == (np ? 32 : 64), np ? "R4 read length" : "R5 read length", fr_n, np ? 32 : 64);
        chk((fr_b & fr_o) == e, "R5 read header bits", fr_b & fr_o, e);
        chk(fr_o == eo, "R5 release pattern", fr_o, eo);
        chk(rd_data == resp, "R5 read data", rd_data, resp);
        chk(upd_n == u0 + 1 && upd_busy == 1'b0, "R9 update strobe at busy fall", upd_busy, 0);
        step();
        chk(link_fail == lf0, "R10 plain read leaves link_fail", link_fail, lf0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int dl[9];
        rst = 1'b1; clk_div = 8'd4; skip_preamble = 0; phy_addr = 0; reg_addr = 0;
        wr_data = 0; req_write = 0; req_read = 0; req_scan = 0;
        phy_resp = 16'h0; cur_nopre = 0;
        repeat (4) step();
        // R1 reset state
        chk({mdc, mdio_oe, busy, write_start, read_start, rd_data_update, link_fail} == 7'b0,
            "R1 control outputs low", {mdc, mdio_oe, busy, write_start, read_start, rd_data_update, link_fail}, 0);
        chk(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
        chk(scan_invalid == 1'b1, "R1 scan_invalid", scan_invalid, 1);
        rst = 1'b0;
        step();

        // R2 divider sweep
        dl = '{0, 1, 2, 3, 4, 5, 8, 9, 255};
        foreach (dl[k]) begin
            int r0, ev;
            clk_div = dl[k][7:0];
            r0 = rises;
            while (rises < r0 + 3) step();
            ev = ((dl[k] < 2) ? 2 : dl[k]) / 2 * 2;
            chk(period == ev, "R2 mdc period", period, ev);
        end

        // R3 / R4 write sweep over addresses, data and divider
        for (int i = 0; i < 6; i++) begin
            clk_div = (i < 3) ? 8'd4 : 8'd2;
            do_write(5'((i * 11 + 3) % 32), 5'((i * 7 + 1) % 32),
                     16'hA5C3 ^ 16'(i * 16'h1111), i[0]);
        end
        do_write(5'h1F, 5'h1F, 16'hFFFF, 1'b0);
        do_write(5'h00, 5'h00, 16'h0000, 1'b1);

        // R5 reads
        clk_div = 8'd4;
        do_read(5'h03, 5'h11, 16'h8001, 1'b0);
        do_read(5'h1A, 5'h05, 16'h7FFE, 1'b1);
        clk_div = 8'd2;
        do_read(5'h15, 5'h0A, 16'h5A3C, 1'b0);
        clk_div = 8'd4;

        // R8 priority, R10 / R11 polling
        begin
            int w0, r0;
            cur_nopre = 0; skip_preamble = 0; phy_addr = 5'h09; reg_addr = 5'h01;
            wr_data = 16'hBEEF; phy_resp = 16'h1238;
            req_write = 1; req_read = 1; req_scan = 1;
            do step(); while (!(write_start || read_start));
            chk(write_start && !read_start, "R8 write served first", {write_start, read_start}, 2'b10);
            req_write = 0;
            chk(scan_invalid == 1'b1, "R11 invalid before first poll", scan_invalid, 1);
            w0 = frames;
            do step(); while (!read_start);
            chk(frames == w0 + 1 && fr_b[29:28] == 2'b01, "R8 read after write frame", fr_b[29:28], 2'b01);
            req_read = 0;
            step();
            w0 = ws_n; r0 = rs_n;
            wait_frame();
            chk(rd_data == 16'h1238, "R5 read data in mixed queue", rd_data, 16'h1238);
            chk(scan_invalid == 1'b1, "R11 plain read keeps invalid", scan_invalid, 1);
            wait_frame();
            chk(fr_b[29:28] == 2'b10, "R10 poll frame uses read opcode", fr_b[29:28], 2'b10);
            chk(link_fail == 1'b1, "R10 link bit 0 gives link_fail", link_fail, 1);
            chk(scan_invalid == 1'b0, "R11 cleared after first poll", scan_invalid, 0);
            phy_resp = 16'h0004;
            wait_frame();
            chk(rd_data == 16'h0004, "R10 poll result", rd_data, 16'h0004);
            chk(link_fail == 1'b0, "R10 link bit 1 clears link_fail", link_fail, 0);
            chk(ws_n == w0 && rs_n == r0, "R7 no start pulse for poll", rs_n, r0);
            req_scan = 0;
            step();
            chk(scan_invalid == 1'b1, "R11 invalid when poll dropped", scan_invalid, 1);
            while (busy) step();
            step();
        end

        // R10 plain read with link bit 0 must not touch link_fail
        do_read(5'h02, 5'h01, 16'h0000, 1'b0);
        chk(link_fail == 1'b0, "R10 link_fail after plain read", link_fail, 0);

        chk(bad_drive == 0, "R6 drive changes only at mdc fall", bad_drive, 0);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule